// File: doc/BRIEF.md
# Video Clip and Horizontal Decimate

This block resizes a streaming video frame after colour conversion in a camera capture path. Each input frame is 720 samples wide and 244 lines tall. The block first crops a fixed 640 x 240 window out of that frame. The crop starts at a parameterised left column and top line. It then halves the width by keeping only the even-indexed columns of the window. The result is a 320 x 240 frame. The line count only shrinks through the crop; there is no vertical scaling.

Both sides are valid/ready pixel streams that carry 8-bit RGB 3-3-2 pixels and start-of-frame and end-of-frame markers. Pixels pass through unchanged. Pixels the block keeps land in a single output register, so a held-back output stalls the input. Pixels it throws away are taken without regard to the output side. The block is meant to sit after the colour space converter. Placed before it, it would decimate chroma-subsampled samples and spoil the picture.

Top module: `vclip_hdecim`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1 while no input is offered.
- R2: Only input pixels with column in [CLIP_L, CLIP_L+WIN_W) and line in [CLIP_T, CLIP_T+WIN_H) can reach the output. Every pixel sent in is accounted for in order: no extra or missing output.
- R3: Inside the window, a pixel is forwarded when (column - CLIP_L) is even and dropped when it is odd. Output pixels keep input order.
- R4: in_data (8 bits, RGB 3-3-2) appears on out_data unchanged.
- R5: out_sof is 1 exactly on the output pixel taken from column CLIP_L of line CLIP_T.
- R6: out_eof is 1 exactly on the output pixel taken from column CLIP_L+WIN_W-2 of line CLIP_T+WIN_H-1.
- R7: A kept pixel accepted at a clock edge is on out_valid/out_data right after that same edge.
- R8: While out_valid is 1 and out_ready is 0, out_data, out_sof and out_eof stay stable, and a kept input pixel sees in_ready 0.
- R9: An input pixel that is dropped sees in_ready 1 whatever out_ready is.
- R10: A pixel with in_sof set is taken as column 0, line 0. The pixel after one with in_eof set is column 0, line 0 even without in_sof.
- R11: A clean frame produces exactly (WIN_W/2)*WIN_H output pixels, from out_sof to out_eof inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_data | input | PIX_W | Input pixel, RGB 3-3-2 |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_eof | input | 1 | Input pixel is the last of a frame |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink takes the output pixel |
| out_data | output | PIX_W | Output pixel |
| out_sof | output | 1 | First pixel of the output frame |
| out_eof | output | 1 | Last pixel of the output frame |

## Verification
A kept pixel is due on the output registers one edge after its input handshake. The driver therefore looks at out_valid and out_data one time unit after that edge. It does so before the sink can change out_ready. The decision to drop a pixel and the stall on a kept one act within the same cycle through in_ready. The driver checks that signal two time units after it drives a beat, once the ready pattern for that cycle has settled. A scoreboard queue compares every output transfer against the model's order, independent of latency. The bench uses a small frame (24 x 8 input, 16 x 4 window) so that many frames, stalls and restarts fit in the run.

// File: rtl/vch_pkg.sv
package vch_pkg;

  // Frame markers that travel with a pixel.
  typedef struct packed {
    logic sof;
    logic eof;
  } vch_mark_t;

endpackage

// File: rtl/vch_rst_sync.sv
module vch_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/vch_pos_track.sv
module vch_pos_track #(
  parameter int IN_W = 720,
  parameter int IN_H = 244,
  parameter int CW   = 10,
  parameter int RW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_fire,
  input  logic          beat_sof,
  input  logic          beat_eof,
  output logic [CW-1:0] cur_col,
  output logic [RW-1:0] cur_row
);

  localparam logic [CW-1:0] COL_LAST = CW'(IN_W - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(IN_H - 1);

  logic [CW-1:0] col_q, col_d;
  logic [RW-1:0] row_q, row_d;

  // Position of the beat on the bus, and position of the one after it.
  always_comb begin
    cur_col = beat_sof ? '0 : col_q;
    cur_row = beat_sof ? '0 : row_q;
    col_d   = col_q;
    row_d   = row_q;
    if (beat_eof) begin
      col_d = '0;
      row_d = '0;
    end else if (cur_col == COL_LAST) begin
      col_d = '0;
      row_d = (cur_row == ROW_LAST) ? '0 : cur_row + 1'b1;
    end else begin
      col_d = cur_col + 1'b1;
      row_d = cur_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (beat_fire) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  // R2: the tracked position never leaves the input frame.
  p_pos_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q <= COL_LAST) && (row_q <= ROW_LAST));

  // R10: a beat carrying the end marker restarts the position at the origin.
  p_eof_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && beat_eof) |=> (col_q == '0) && (row_q == '0));

endmodule

// File: rtl/vch_keep_decide.sv
module vch_keep_decide #(
  parameter int CLIP_L   = 40,
  parameter int CLIP_T   = 2,
  parameter int WIN_W    = 640,
  parameter int WIN_H    = 240,
  parameter bit KEEP_ODD = 1'b0,
  parameter int CW       = 10,
  parameter int RW       = 8
) (
  input  logic [CW-1:0] col,
  input  logic [RW-1:0] row,
  output logic          keep,
  output logic          first,
  output logic          last
);

  localparam logic [CW:0]   C_LO    = (CW+1)'(CLIP_L);
  localparam logic [CW:0]   C_HI    = (CW+1)'(CLIP_L + WIN_W);
  localparam logic [RW:0]   R_LO    = (RW+1)'(CLIP_T);
  localparam logic [RW:0]   R_HI    = (RW+1)'(CLIP_T + WIN_H);
  localparam logic          L_PAR   = 1'(CLIP_L % 2);
  localparam logic [CW-1:0] C_FIRST = CW'(CLIP_L + int'(KEEP_ODD));
  localparam logic [CW-1:0] C_LAST  = CW'(CLIP_L + WIN_W - 2 + int'(KEEP_ODD));
  localparam logic [RW-1:0] R_FIRST = RW'(CLIP_T);
  localparam logic [RW-1:0] R_LAST  = RW'(CLIP_T + WIN_H - 1);

  logic in_cols;
  logic in_rows;
  logic rel_odd;
  logic phase_ok;

  always_comb begin
    in_cols = ({1'b0, col} >= C_LO) && ({1'b0, col} < C_HI);
    in_rows = ({1'b0, row} >= R_LO) && ({1'b0, row} < R_HI);
    rel_odd = col[0] ^ L_PAR;
  end

  generate
    if (KEEP_ODD) begin : g_keep_odd
      assign phase_ok = rel_odd;
    end else begin : g_keep_even
      assign phase_ok = ~rel_odd;
    end
  endgenerate

  always_comb begin
    keep  = in_cols && in_rows && phase_ok;
    first = keep && (row == R_FIRST) && (col == C_FIRST);
    last  = keep && (row == R_LAST) && (col == C_LAST);
  end

endmodule

// File: rtl/vch_out_stage.sv
module vch_out_stage
  import vch_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] load_data,
  input  vch_mark_t        load_mark,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output vch_mark_t        out_mark,
  output logic             space
);

  logic             valid_q, valid_d;
  logic [PIX_W-1:0] data_q;
  vch_mark_t        mark_q;

  always_comb begin
    space   = !valid_q || out_ready;
    valid_d = valid_q;
    if (load) begin
      valid_d = 1'b1;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mark_q <= '0;
    end else if (load) begin
      data_q <= load_data;
      mark_q <= load_mark;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_mark  = mark_q;

  // R8: a held output is not disturbed until the sink takes it.
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready) |=> valid_q && $stable(data_q) && $stable(mark_q));

  // R8: the upstream never loads over an untaken pixel.
  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!valid_q || out_ready));

endmodule

// File: rtl/vclip_hdecim.sv
module vclip_hdecim
  import vch_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int IN_W     = 720,
  parameter int IN_H     = 244,
  parameter int CLIP_L   = 40,
  parameter int CLIP_T   = 2,
  parameter int WIN_W    = 640,
  parameter int WIN_H    = 240,
  parameter bit KEEP_ODD = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sof,
  output logic             out_eof
);

  localparam int CW        = $clog2(IN_W);
  localparam int RW        = $clog2(IN_H);
  localparam int OUT_W     = WIN_W / 2;
  localparam int OUT_TOTAL = OUT_W * WIN_H;
  localparam int FW        = $clog2(OUT_TOTAL + 1);

  logic          rst_sync_n;
  logic [CW-1:0] cur_col;
  logic [RW-1:0] cur_row;
  logic          keep;
  logic          first;
  logic          last;
  logic          space;
  logic          fire;
  logic          load;
  vch_mark_t     load_mark;
  vch_mark_t     out_mark;

  vch_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vch_pos_track #(
    .IN_W (IN_W),
    .IN_H (IN_H),
    .CW   (CW),
    .RW   (RW)
  ) u_pos (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .beat_fire (fire),
    .beat_sof  (in_sof),
    .beat_eof  (in_eof),
    .cur_col   (cur_col),
    .cur_row   (cur_row)
  );

  vch_keep_decide #(
    .CLIP_L   (CLIP_L),
    .CLIP_T   (CLIP_T),
    .WIN_W    (WIN_W),
    .WIN_H    (WIN_H),
    .KEEP_ODD (KEEP_ODD),
    .CW       (CW),
    .RW       (RW)
  ) u_keep (
    .col   (cur_col),
    .row   (cur_row),
    .keep  (keep),
    .first (first),
    .last  (last)
  );

  // Dropped pixels never wait; kept ones wait for room in the output register.
  always_comb begin
    in_ready      = !keep || space;
    fire          = in_valid && in_ready;
    load          = fire && keep;
    load_mark.sof = first;
    load_mark.eof = last;
  end

  vch_out_stage #(
    .PIX_W (PIX_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .load_data (in_data),
    .load_mark (load_mark),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_mark  (out_mark),
    .space     (space)
  );

  assign out_sof = out_mark.sof;
  assign out_eof = out_mark.eof;

  // Checker state: output transfers counted since the last start marker.
  logic          out_fire;
  logic          seen_sof_q;
  logic [FW-1:0] beat_cnt_q;

  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      seen_sof_q <= 1'b0;
      beat_cnt_q <= '0;
    end else if (out_fire) begin
      if (out_sof) begin
        seen_sof_q <= 1'b1;
        beat_cnt_q <= FW'(1);
      end else begin
        beat_cnt_q <= beat_cnt_q + 1'b1;
      end
    end
  end

  // R9: a pixel that is dropped is always taken at once.
  p_drop_no_wait_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !keep) |-> in_ready);

  // R5/R6: start and end markers never share an output pixel.
  p_marks_apart_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> !(out_sof && out_eof));

  // R11: a frame closes after exactly the decimated window size.
  p_frame_len_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_fire && out_eof && seen_sof_q) |-> (beat_cnt_q == FW'(OUT_TOTAL - 1)));

  // R7: a kept pixel is presented right after its handshake.
  p_kept_shows_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load |=> out_valid);

endmodule

// File: tb/vclip_hdecim_tb.sv
module vclip_hdecim_tb_top;

  localparam int IN_W  = 24;
  localparam int IN_H  = 8;
  localparam int CL    = 4;
  localparam int CT    = 2;
  localparam int WW    = 16;
  localparam int WH    = 4;
  localparam int OUT_N = (WW / 2) * WH;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       in_sof;
  logic       in_eof;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;
  logic       out_sof;
  logic       out_eof;

  vclip_hdecim #(
    .PIX_W    (8),
    .IN_W     (IN_W),
    .IN_H     (IN_H),
    .CLIP_L   (CL),
    .CLIP_T   (CT),
    .WIN_W    (WW),
    .WIN_H    (WH),
    .KEEP_ODD (1'b0)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [7:0] d;
    logic       s;
    logic       e;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   mcol   = 0;
  int   mrow   = 0;
  int   rmode  = 0;
  int   cyc    = 0;
  bit   done_all = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Offer one pixel, model its fate, and wait for the handshake.
  task automatic send_beat(input logic [7:0] d, input logic s, input logic e);
    int c;
    int r;
    bit k;
    bit fs;
    bit fe;
    bit done;
    c  = s ? 0 : mcol;
    r  = s ? 0 : mrow;
    k  = (r >= CT) && (r < CT + WH) && (c >= CL) && (c < CL + WW) && (((c - CL) % 2) == 0);
    fs = k && (r == CT) && (c == CL);
    fe = k && (r == CT + WH - 1) && (c == CL + WW - 2);
    done = 0;
    while (!done) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      in_sof   = s;
      in_eof   = e;
      #2;
      if (!k) begin
        check(in_ready == 1'b1, "R9 dropped pixel ready", int'(in_ready), 1);
      end else if (out_valid && !out_ready) begin
        check(in_ready == 1'b0, "R8 kept pixel stalled", int'(in_ready), 0);
      end
      if (in_ready) begin
        if (k) q.push_back('{d: d, s: fs, e: fe});
        done = 1;
      end
    end
    @(posedge clk);
    #1;
    if (e) begin
      mcol = 0;
      mrow = 0;
    end else if (c == IN_W - 1) begin
      mcol = 0;
      mrow = (r == IN_H - 1) ? 0 : r + 1;
    end else begin
      mcol = c + 1;
      mrow = r;
    end
    if (k) begin
      check(out_valid == 1'b1, "R7 kept pixel valid after edge", int'(out_valid), 1);
      check(out_data == d, "R7 kept pixel data after edge", int'(out_data), int'(d));
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_eof   = 1'b0;
    end
  endtask

  task automatic send_frame(input int f, input bit use_sof, input int nb,
                            input bit put_eof, input bit gaps);
    for (int i = 0; i < nb; i++) begin
      int c;
      int r;
      c = i % IN_W;
      r = i / IN_W;
      send_beat(8'((c * 5) + (r * 17) + (f * 3)), use_sof && (i == 0),
                put_eof && (i == nb - 1));
      if (gaps && ((i % 5) == 4)) idle(1);
    end
    idle(1);
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      if ((q.size() == 0) && !out_valid) break;
      @(negedge clk);
    end
    #3;
    check(q.size() == 0, "R2 scoreboard empty after frame", q.size(), 0);
  endtask

  // Sink: sets out_ready, compares every transfer against the queue.
  initial begin
    bit         prev_stall;
    logic [7:0] prev_data;
    int         fcnt;
    prev_stall = 0;
    prev_data  = '0;
    fcnt       = 0;
    out_ready  = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      case (rmode)
        1:       out_ready = (cyc % 3) != 0;
        2:       out_ready = (cyc % 7) >= 4;
        default: out_ready = 1'b1;
      endcase
      #2;
      if (rst_n && prev_stall) begin
        check(out_valid == 1'b1, "R8 held valid", int'(out_valid), 1);
        check(out_data == prev_data, "R8 held data", int'(out_data), int'(prev_data));
      end
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected output pixel", int'(out_data), -1);
        end else begin
          exp_t ex;
          ex = q.pop_front();
          check(out_data == ex.d, "R2/R3/R4 pixel data", int'(out_data), int'(ex.d));
          check(out_sof == ex.s, "R5 start marker", int'(out_sof), int'(ex.s));
          check(out_eof == ex.e, "R6 end marker", int'(out_eof), int'(ex.e));
        end
        if (out_sof) fcnt = 1;
        else fcnt++;
        if (out_eof) check(fcnt == OUT_N, "R11 output frame length", fcnt, OUT_N);
      end
      prev_stall = rst_n && out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    if (!done_all) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);

    // Clean frame, sink always ready.
    rmode = 0;
    send_frame(1, 1'b1, IN_W * IN_H, 1'b1, 1'b0);
    drain();

    // Clean frame with input gaps and a stalling sink.
    rmode = 1;
    send_frame(2, 1'b1, IN_W * IN_H, 1'b1, 1'b1);
    drain();

    // R10: frame abandoned mid-window, restarted by a start marker.
    rmode = 2;
    send_frame(3, 1'b1, 60, 1'b0, 1'b0);
    send_frame(4, 1'b1, IN_W * IN_H, 1'b1, 1'b0);
    drain();

    // R10: frame cut short by an end marker, next frame sent without a start marker.
    send_frame(5, 1'b1, 70, 1'b1, 1'b0);
    send_frame(6, 1'b0, IN_W * IN_H, 1'b1, 1'b1);
    drain();

    // Back to back clean frames under heavy stall.
    rmode = 1;
    send_frame(7, 1'b1, IN_W * IN_H, 1'b1, 1'b0);
    send_frame(8, 1'b1, IN_W * IN_H, 1'b1, 1'b0);
    drain();

    done_all = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule